// File: doc/BRIEF.md
# Four-Character Aligning Demultiplexer

This block takes one 10-bit character per clock from a receive channel and packs four consecutive characters into a single 40-bit word. It raises a one-cycle strobe each time a full word is ready. A slower consumer reads the packed words. The boundary between words is not fixed. Whenever the selected synchronizing character arrives, the grouping is re-anchored so that this character opens a new word in lane 0.

Characters come in one of two forms, chosen by `dec_en`:

- **Decoded form** (`dec_en` = 1): bits 7:0 hold a byte, bit 8 flags a special character, and bit 9 carries a status indication.
- **Raw form** (`dec_en` = 0): the character is an undecoded 10-bit code group.

`sync_sel` chooses which character synchronizes the grouping: the comma, or the lane alignment character /A/. The /A/ character is only recognised in decoded form. A status output reports that the grouping has been anchored by a sync character. That status clears when the operating mode changes.

Top module: `quad_char_demux`

## Requirements
- R1: Output lane k occupies `word_out[10k+9:10k]`, and lane 0 holds the earliest character of the word. All ten bits of each character, including the status bit 9, reach the output unchanged.
- R2: `word_vld` is high for exactly one cycle, namely the cycle after the fourth character of a word is accepted. `word_out` holds its value between strobes.
- R3: A cycle with `char_vld` low consumes no lane and produces no strobe in the following cycle.
- R4: When a sync character is accepted while lanes 1..3 would be next, the partly filled word is discarded with no strobe, and the sync character becomes lane 0 of a new word.
- R5: With `dec_en`=1 and `sync_sel`=0, a character is a sync character when its bits 8:0 equal 9'h1BC. Bit 9 plays no part in this match.
- R6: With `dec_en`=1 and `sync_sel`=1, a character is a sync character when its bits 8:0 equal 9'h17C. In this mode the comma is treated as ordinary data.
- R7: With `dec_en`=0 and `sync_sel`=0, a character is a sync character when all ten bits equal 10'h0FA or 10'h305. These are the two disparities of the comma code group, with the first transmitted code bit in bit 9.
- R8: With `dec_en`=0 and `sync_sel`=1, no character is treated as a sync character, and `aligned` stays low.
- R9: `aligned` rises in the cycle after the first accepted sync character. It stays high for as long as the mode is unchanged.
- R10: When {`dec_en`,`sync_sel`} differs from its value in the previous cycle, `aligned` clears, the partial word is discarded, and the character presented in that cycle is dropped.
- R11: While `rst_n` is low, `word_out`, `word_vld` and `aligned` are 0, and the next accepted character fills lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_vld | input | 1 | A character is presented this cycle |
| char_in | input | 10 | Incoming character |
| dec_en | input | 1 | 1 = decoded characters, 0 = raw code groups |
| sync_sel | input | 1 | 0 = comma synchronizes, 1 = /A/ synchronizes |
| word_out | output | 40 | Packed four-character word, lane 0 in bits 9:0 |
| word_vld | output | 1 | One-cycle strobe marking a new `word_out` |
| aligned | output | 1 | Grouping has been anchored by a sync character |

## Verification
The assertions check several properties on every cycle:

- the strobe is never longer than one cycle;
- the word holds steady between strobes;
- an idle cycle never produces a strobe;
- a mode change clears `aligned` and suppresses the strobe;
- `aligned` persists while the mode is steady;
- `aligned` cannot rise in raw mode with /A/ selected.

The lane ordering, the discarding of partial words on realignment, and the exact code values matched in each mode depend on the content of a whole sequence. Only the bench's scenarios show these, with its reference model compared against the outputs every cycle.

// File: rtl/qcd_pkg.sv
package qcd_pkg;
   localparam int CHAR_W = 10;

   typedef enum logic {
      SYNC_COMMA = 1'b0,
      SYNC_ALIGN = 1'b1
   } sync_sel_e;

   typedef struct packed {
      logic      dec_en;
      sync_sel_e sel;
   } mode_t;

   // decoded matches use the special flag plus byte (bits 8:0)
   localparam logic [8:0] DEC_COMMA = 9'h1BC;
   localparam logic [8:0] DEC_ALIGN = 9'h17C;
   // raw comma code group, both running disparities
   localparam logic [CHAR_W-1:0] RAW_COMMA_N = 10'h0FA;
   localparam logic [CHAR_W-1:0] RAW_COMMA_P = 10'h305;
endpackage

// File: rtl/qcd_sync_detect.sv
module qcd_sync_detect
   import qcd_pkg::*;
#(
   parameter bit RAW_MATCH_EN = 1'b1
) (
   input  logic [CHAR_W-1:0] char_in,
   input  mode_t             mode,
   output logic              is_sync
);
   logic dec_hit;
   logic raw_hit;

   always_comb begin
      dec_hit = 1'b0;
      if (mode.sel == SYNC_ALIGN) dec_hit = (char_in[8:0] == DEC_ALIGN);
      else                        dec_hit = (char_in[8:0] == DEC_COMMA);
   end

   generate
      if (RAW_MATCH_EN) begin : g_raw
         always_comb begin
            raw_hit = 1'b0;
            if (mode.sel == SYNC_COMMA)
               raw_hit = (char_in == RAW_COMMA_N) || (char_in == RAW_COMMA_P);
         end
      end else begin : g_noraw
         assign raw_hit = 1'b0;
      end
   endgenerate

   assign is_sync = mode.dec_en ? dec_hit : raw_hit;
endmodule

// File: rtl/qcd_mode_watch.sv
module qcd_mode_watch
   import qcd_pkg::*;
(
   input  logic  clk,
   input  mode_t mode,
   output logic  mode_chg
);
   mode_t mode_q;

   // tracked through reset so the first cycle after it sees no change
   always_ff @(posedge clk) mode_q <= mode;

   assign mode_chg = (mode_q != mode);
endmodule

// File: rtl/qcd_lane_collect.sv
module qcd_lane_collect
   import qcd_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    accept,
   input  logic                    is_sync,
   input  logic                    flush,
   input  logic [CHAR_W-1:0]       char_in,
   output logic [LANES*CHAR_W-1:0] word_out,
   output logic                    word_vld
);
   localparam int IDX_W = (LANES > 2) ? $clog2(LANES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);
   localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

   logic [IDX_W-1:0]        idx_q;
   logic [IDX_W-1:0]        wr_idx;
   logic                    complete;
   logic [LANES*CHAR_W-1:0] word_next;

   assign wr_idx   = is_sync ? '0 : idx_q;
   assign complete = accept && !is_sync && (idx_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)                  idx_q <= '0;
      else if (flush)              idx_q <= '0;
      else if (accept && is_sync)  idx_q <= ONE;
      else if (complete)           idx_q <= '0;
      else if (accept)             idx_q <= idx_q + ONE;
   end

   genvar k;
   generate
      for (k = 0; k < LANES - 1; k++) begin : g_lane
         logic [CHAR_W-1:0] lane_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               lane_q <= '0;
            else if (accept && (wr_idx == IDX_W'(k)))
               lane_q <= char_in;
         end
         assign word_next[k*CHAR_W +: CHAR_W] = lane_q;
      end
   endgenerate

   // final lane is taken straight from the input
   assign word_next[(LANES-1)*CHAR_W +: CHAR_W] = char_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_out <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= complete;
         if (complete) word_out <= word_next;
      end
   end
endmodule

// File: rtl/qcd_align_track.sv
module qcd_align_track (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_chg,
   input  logic sync_taken,
   output logic aligned
);
   always_ff @(posedge clk) begin
      if (!rst_n)          aligned <= 1'b0;
      else if (mode_chg)   aligned <= 1'b0;
      else if (sync_taken) aligned <= 1'b1;
   end
endmodule

// File: rtl/quad_char_demux.sv
module quad_char_demux
   import qcd_pkg::*;
#(
   parameter int LANES        = 4,
   parameter bit RAW_MATCH_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    char_vld,
   input  logic [9:0]              char_in,
   input  logic                    dec_en,
   input  logic                    sync_sel,
   output logic [LANES*10-1:0]     word_out,
   output logic                    word_vld,
   output logic                    aligned
);
   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("quad_char_demux: LANES must be at least 2");
      end
      if (CHAR_W != 10) begin : g_bad_width
         $error("quad_char_demux: character width must be 10");
      end
   endgenerate

   mode_t mode;
   logic  mode_chg;
   logic  is_sync;
   logic  accept;

   assign mode.dec_en = dec_en;
   assign mode.sel    = sync_sel_e'(sync_sel);
   assign accept      = char_vld && !mode_chg;

   qcd_mode_watch i_mode (
      .clk      (clk),
      .mode     (mode),
      .mode_chg (mode_chg)
   );

   qcd_sync_detect #(.RAW_MATCH_EN(RAW_MATCH_EN)) i_det (
      .char_in (char_in),
      .mode    (mode),
      .is_sync (is_sync)
   );

   qcd_lane_collect #(.LANES(LANES)) i_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .is_sync  (is_sync),
      .flush    (mode_chg),
      .char_in  (char_in),
      .word_out (word_out),
      .word_vld (word_vld)
   );

   qcd_align_track i_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_chg   (mode_chg),
      .sync_taken (accept && is_sync),
      .aligned    (aligned)
   );
endmodule

// File: rtl/qcd_checker.sv
module qcd_checker #(
   parameter int LANES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                char_vld,
   input logic                dec_en,
   input logic                sync_sel,
   input logic [LANES*10-1:0] word_out,
   input logic                word_vld,
   input logic                aligned
);
   logic [1:0] mode_seen_q;
   logic       mode_moved;

   always_ff @(posedge clk) mode_seen_q <= {dec_en, sync_sel};
   assign mode_moved = (mode_seen_q != {dec_en, sync_sel});

   AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);                                   // R2
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> $stable(word_out));                          // R2
   AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      !char_vld |=> !word_vld);                                  // R3
   AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      mode_moved |=> !aligned);                                  // R10
   AST_MODE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_moved |=> !word_vld);                                 // R10
   AST_ALIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned && !mode_moved) |=> aligned);                     // R9
   AST_RAW_A_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_en && sync_sel && !aligned) |=> !aligned);           // R8
endmodule

bind quad_char_demux qcd_checker #(.LANES(LANES)) i_qcd_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .char_vld (char_vld),
   .dec_en   (dec_en),
   .sync_sel (sync_sel),
   .word_out (word_out),
   .word_vld (word_vld),
   .aligned  (aligned)
);

// File: tb/test_quad_char_demux.sv
module test_quad_char_demux;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        char_vld;
   logic [9:0]  char_in;
   logic        dec_en;
   logic        sync_sel;
   logic [39:0] word_out;
   logic        word_vld;
   logic        aligned;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   quad_char_demux i_quad_char_demux (
      .clk(clk), .rst_n(rst_n), .char_vld(char_vld), .char_in(char_in),
      .dec_en(dec_en), .sync_sel(sync_sel), .word_out(word_out),
      .word_vld(word_vld), .aligned(aligned)
   );

   // ---------------- reference model ----------------
   logic [9:0]  q[$];
   logic [39:0] m_word = '0;
   logic        m_vld = 1'b0;
   logic        m_aln = 1'b0;
   logic [1:0]  m_mode = '0;

   function automatic bit is_sync_ref(logic [9:0] c, logic d, logic s);
      if (d) return s ? (c[8:0] == 9'h17C) : (c[8:0] == 9'h1BC);
      return !s && (c == 10'h0FA || c == 10'h305);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); m_word = '0; m_vld = 1'b0; m_aln = 1'b0;
      end else begin
         m_vld = 1'b0;
         if ({dec_en, sync_sel} != m_mode) begin
            q.delete(); m_aln = 1'b0;
         end else if (char_vld) begin
            if (is_sync_ref(char_in, dec_en, sync_sel)) begin
               m_aln = 1'b1;
               q.delete();
            end
            q.push_back(char_in);
            if (q.size() == 4) begin
               m_word = {q[3], q[2], q[1], q[0]};
               m_vld = 1'b1;
               q.delete();
            end
         end
      end
      m_mode = {dec_en, sync_sel};
   end

   task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      chk("R2 word_vld", {39'd0, word_vld}, {39'd0, m_vld});
      chk("R9 aligned", {39'd0, aligned}, {39'd0, m_aln});
      if (m_vld) chk("R1 word_out", word_out, m_word);
   endtask

   // drive at a falling edge, return at the next falling edge
   task automatic step(logic v, logic [9:0] c);
      char_vld = v; char_in = c;
      @(negedge clk);
      compare_model();
   endtask

   task automatic set_mode(logic d, logic s);
      dec_en = d; sync_sel = s;
      step(1'b1, 10'h055);   // dropped by the mode change
   endtask

   initial begin
      rst_n = 1'b0; char_vld = 1'b0; char_in = '0; dec_en = 1'b1; sync_sel = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 word_out", word_out, '0);
      chk("R11 word_vld", {39'd0, word_vld}, '0);
      chk("R11 aligned", {39'd0, aligned}, '0);
      rst_n = 1'b1;

      // R1: plain packing, status bit 9 carried
      step(1, 10'h201); step(1, 10'h002); step(1, 10'h203); step(1, 10'h104);
      chk("R1 lane order", word_out, {10'h104, 10'h203, 10'h002, 10'h201});
      chk("R11 first lane after reset", {39'd0, word_vld}, 40'd1);

      // R3: idle cycles consume no lane
      step(1, 10'h011); step(0, 10'h1BC); step(1, 10'h012);
      chk("R3 no strobe on idle", {39'd0, word_vld}, '0);
      step(0, 10'h3FF); step(1, 10'h013); step(1, 10'h014);
      chk("R3 word after gaps", word_out, {10'h014, 10'h013, 10'h012, 10'h011});

      // R4, R5: comma with bit 9 set in lane 2 realigns
      step(1, 10'h021); step(1, 10'h022); step(1, 10'h3BC);
      chk("R4 no strobe on drop", {39'd0, word_vld}, '0);
      chk("R9 aligned after sync", {39'd0, aligned}, 40'd1);
      step(1, 10'h023); step(1, 10'h024); step(1, 10'h025);
      chk("R5 comma leads word", word_out, {10'h025, 10'h024, 10'h023, 10'h3BC});

      // R10, R6: switch to /A/ sync
      set_mode(1, 1);
      chk("R10 aligned cleared", {39'd0, aligned}, '0);
      step(1, 10'h031); step(1, 10'h1BC); step(1, 10'h032); step(1, 10'h033);
      chk("R6 comma is data", word_out, {10'h033, 10'h032, 10'h1BC, 10'h031});
      step(1, 10'h034); step(1, 10'h17C);
      step(1, 10'h035); step(1, 10'h036); step(1, 10'h037);
      chk("R6 /A/ leads word", word_out, {10'h037, 10'h036, 10'h035, 10'h17C});

      // R10: mode change mid-word discards the partial word
      step(1, 10'h041); step(1, 10'h042);
      set_mode(1, 0);
      step(1, 10'h043); step(1, 10'h044); step(1, 10'h045); step(1, 10'h046);
      chk("R10 fresh word", word_out, {10'h046, 10'h045, 10'h044, 10'h043});

      // R7: raw comma, both disparities
      set_mode(0, 0);
      step(1, 10'h051); step(1, 10'h0FA); step(1, 10'h052); step(1, 10'h053); step(1, 10'h054);
      chk("R7 raw comma neg", word_out, {10'h054, 10'h053, 10'h052, 10'h0FA});
      step(1, 10'h061); step(1, 10'h305); step(1, 10'h062); step(1, 10'h063); step(1, 10'h064);
      chk("R7 raw comma pos", word_out, {10'h064, 10'h063, 10'h062, 10'h305});

      // R8: raw with /A/ selected never synchronizes
      set_mode(0, 1);
      step(1, 10'h071); step(1, 10'h17C); step(1, 10'h0FA); step(1, 10'h305);
      chk("R8 no realign", word_out, {10'h305, 10'h0FA, 10'h17C, 10'h071});
      chk("R8 aligned low", {39'd0, aligned}, '0);

      // random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         logic [9:0] c;
         int r;
         r = $urandom_range(0, 99);
         if (r < 3) begin
            dec_en = $urandom_range(0, 1); sync_sel = $urandom_range(0, 1);
         end
         case ($urandom_range(0, 9))
            0: c = {1'($urandom_range(0, 1)), 9'h1BC};
            1: c = {1'($urandom_range(0, 1)), 9'h17C};
            2: c = 10'h0FA;
            3: c = 10'h305;
            default: c = 10'($urandom);
         endcase
         step($urandom_range(0, 4) != 0, c);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule